// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the synchronous control core of a byte-wide flash bank. It watches write cycles on a shared address/data bus, qualified by a bank select. It accepts alteration commands only after an exact unlock sequence on fixed command addresses. The accepted commands are byte program, sector erase, whole-bank erase, and entry to or exit from an identifier mode. Once an operation is accepted, the bank stays busy for a fixed number of clock cycles. During that time reads return polling status instead of array contents, and further commands are dropped.

The storage is a small behavioural array, written so that a block RAM can be inferred. It is erased (all bytes FFh) at start-up. An erase walks the affected range one byte per clock cycle while the busy timer runs. The busy period ends when both the timer and the walk have finished. A program only clears bits: the new byte is the old byte ANDed with the written data. Sector size is 2^SECT_LSB bytes and array depth is 2^MEM_AW bytes. The sector number comes from address bits [MEM_AW-1:SECT_LSB], and higher bits alias.

A read is one cycle long. Its result appears on `rdata` in the cycle after the read is issued and is valid for that cycle.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After writes of AAh to 5555h, 55h to 2AAAh and A0h to 5555h, the next write programs its data into the array at its address, and that byte reads back once the operation has completed.
- R2: A program only clears bits: the stored byte becomes the previous byte ANDed with the written data.
- R3: During command cycles only address bits [14:0] are compared, so any value on the higher bits still matches 5555h or 2AAAh.
- R4: The write sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, followed by 30h at any address, erases every byte of that address's sector to FFh and leaves the other sectors unchanged.
- R5: The same five writes followed by 10h at 5555h set every byte of the array to FFh.
- R6: A read while busy returns the complement of bit 7 of the programmed data on bit 7 during a program, or 0 on bit 7 during an erase, and 0 on bits [5:0].
- R7: Bit 6 inverts on every successive read while busy and stops toggling once the operation completes.
- R8: For a program, the reads captured in clock cycles 1 to PROG_CYC after the final write return status, and the next read returns array data. Every write made while busy is ignored.
- R9: A write that does not match the expected next step of a sequence returns the decoder to read mode without starting any operation.
- R10: AAh@5555h, 55h@2AAAh, 90h@5555h enter identifier mode. In that mode address 0 reads BFh, address 1 reads DEV_CODE, and any other address reads the array. The mode is left with AAh@5555h, 55h@2AAAh, F0h@5555h, or with a single F0h write at any address when no sequence is pending at the program-data step.
- R11: `rdata` reads 00h out of reset. Reset clears identifier mode and any partial sequence. A read's data is due exactly one cycle after the read.
- R12: An erase sequence whose sixth write carries 10h at an address other than 5555h starts no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | Bank select; qualifies both reads and writes |
| wr_en | input | 1 | Write cycle strobe (one cycle per bus write) |
| rd_en | input | 1 | Read cycle strobe; ignored when wr_en is high |
| addr | input | ADDR_W (19) | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, status or identifier code, valid the cycle after a read |

## Verification
Every read result is due one clock cycle after the read strobe is captured. The bench therefore drives on a falling edge and samples on the next falling edge, just after the capturing rising edge. The busy window for a program is checked read by read. Reads are issued back to back starting in the cycle right after the final write. Reads 1 through PROG_CYC must show status with an alternating bit 6, and read PROG_CYC+1 must show the stored byte. Erase durations depend on the walk length, so the bench polls until two successive reads agree and only then checks array contents.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PROG, SQ_ERS3, SQ_ERS4, SQ_ERS5
  } seq_st_t;

  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_SECT, OP_BANK} op_t;

  localparam logic [14:0] CMD_ADDR_A = 15'h5555;
  localparam logic [14:0] CMD_ADDR_B = 15'h2AAA;
  localparam logic [7:0]  KEY_A      = 8'hAA;
  localparam logic [7:0]  KEY_B      = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_ERASE  = 8'h80;
  localparam logic [7:0]  CMD_SECT   = 8'h30;
  localparam logic [7:0]  CMD_BANK   = 8'h10;
  localparam logic [7:0]  CMD_IDIN   = 8'h90;
  localparam logic [7:0]  CMD_IDOUT  = 8'hF0;
  localparam logic [7:0]  MAKER_CODE = 8'hBF;
  localparam logic [7:0]  ERASED     = 8'hFF;
endpackage

// File: rtl/fcd_array.sv
module fcd_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // power-up contents: erased
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = {DW{1'b1}};
  end

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    q <= mem[ra];
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import flash_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [14:0] cmd_addr,
  input  logic [7:0]  wdata,
  input  logic        busy,
  output logic        start,
  output op_t         op,
  output logic        id_mode
);
  seq_st_t st, st_n;
  logic    id_n, hit_a, hit_b, accept;

  assign hit_a  = (cmd_addr == CMD_ADDR_A);
  assign hit_b  = (cmd_addr == CMD_ADDR_B);
  assign accept = wr && !busy;

  always_comb begin
    st_n  = st;
    id_n  = id_mode;
    start = 1'b0;
    op    = OP_NONE;
    if (accept) begin
      st_n = SQ_IDLE;
      case (st)
        SQ_IDLE: if (wdata == KEY_A && hit_a) st_n = SQ_UNL1;
        SQ_UNL1: if (wdata == KEY_B && hit_b) st_n = SQ_UNL2;
        SQ_UNL2: begin
          if (hit_a) begin
            if (wdata == CMD_PROG)       st_n = SQ_PROG;
            else if (wdata == CMD_ERASE) st_n = SQ_ERS3;
            else if (wdata == CMD_IDIN)  id_n = 1'b1;
          end
        end
        SQ_PROG: begin
          start = 1'b1;
          op    = OP_PROG;
        end
        SQ_ERS3: if (wdata == KEY_A && hit_a) st_n = SQ_ERS4;
        SQ_ERS4: if (wdata == KEY_B && hit_b) st_n = SQ_ERS5;
        SQ_ERS5: begin
          if (wdata == CMD_SECT) begin
            start = 1'b1;
            op    = OP_SECT;
          end else if (wdata == CMD_BANK && hit_a) begin
            start = 1'b1;
            op    = OP_BANK;
          end
        end
        default: st_n = SQ_IDLE;
      endcase
      // a reset byte outside the program-data step always leaves ID mode
      if (st != SQ_PROG && wdata == CMD_IDOUT) begin
        id_n = 1'b0;
        st_n = SQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      id_mode <= 1'b0;
    end else begin
      st      <= st_n;
      id_mode <= id_n;
    end
  end

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr && busy |=> st == $past(st));

  // R10
  id_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(id_mode) |-> $past(wr && wdata == CMD_IDIN));
endmodule

// File: rtl/fcd_engine.sv
module fcd_engine
  import flash_cmd_pkg::*;
#(
  parameter int MEM_AW   = 11,
  parameter int SECT_LSB = 9,
  parameter int PROG_CYC = 8,
  parameter int SECT_CYC = 600,
  parameter int BANK_CYC = 2100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  op_t               op_in,
  input  logic [MEM_AW-1:0] addr_in,
  input  logic [7:0]        data_in,
  input  logic [7:0]        ram_q,
  output logic              busy,
  output logic              is_prog,
  output logic              prog_d7,
  output logic              ram_we,
  output logic [MEM_AW-1:0] ram_wa,
  output logic [7:0]        ram_wd,
  output logic [MEM_AW-1:0] eng_ra
);
  localparam int ERS_MAX = (BANK_CYC > SECT_CYC) ? BANK_CYC : SECT_CYC;
  localparam int MAXC    = (ERS_MAX > PROG_CYC) ? ERS_MAX : PROG_CYC;
  localparam int TW      = $clog2(MAXC + 1);
  localparam int SECT_SZ = 1 << SECT_LSB;
  localparam int MEM_SZ  = 1 << MEM_AW;

  op_t               op_q;
  logic [MEM_AW-1:0] addr_q, wptr;
  logic [MEM_AW:0]   wleft;
  logic [7:0]        data_q;
  logic [TW-1:0]     tmr;
  logic [1:0]        ph;
  logic              walk_done;

  assign walk_done = (op_q == OP_PROG) ? (ph == 2'd2) : (wleft == '0);
  assign is_prog   = (op_q == OP_PROG);
  assign prog_d7   = data_q[7];
  assign eng_ra    = addr_q;
  assign ram_we    = busy && (is_prog ? (ph == 2'd1) : (wleft != '0));
  assign ram_wa    = is_prog ? addr_q : wptr;
  assign ram_wd    = is_prog ? (ram_q & data_q) : ERASED;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      op_q   <= OP_NONE;
      addr_q <= '0;
      data_q <= '0;
      tmr    <= '0;
      ph     <= '0;
      wptr   <= '0;
      wleft  <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      op_q   <= op_in;
      addr_q <= addr_in;
      data_q <= data_in;
      ph     <= '0;
      case (op_in)
        OP_PROG: begin
          tmr   <= TW'(PROG_CYC - 1);
          wptr  <= '0;
          wleft <= '0;
        end
        OP_SECT: begin
          tmr   <= TW'(SECT_CYC - 1);
          wptr  <= {addr_in[MEM_AW-1:SECT_LSB], {SECT_LSB{1'b0}}};
          wleft <= (MEM_AW+1)'(SECT_SZ);
        end
        OP_BANK: begin
          tmr   <= TW'(BANK_CYC - 1);
          wptr  <= '0;
          wleft <= (MEM_AW+1)'(MEM_SZ);
        end
        default: begin
          tmr   <= '0;
          wptr  <= '0;
          wleft <= '0;
        end
      endcase
    end else if (busy) begin
      if (ph != 2'd2) ph <= ph + 2'd1;
      if (!is_prog && wleft != '0) begin
        wptr  <= wptr + 1'b1;
        wleft <= wleft - 1'b1;
      end
      if (tmr != '0) tmr <= tmr - 1'b1;
      else if (walk_done) busy <= 1'b0;
    end
  end

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(tmr) == '0);

  // R4
  walk_range_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we && op_q == OP_SECT |->
      ram_wa[MEM_AW-1:SECT_LSB] == addr_q[MEM_AW-1:SECT_LSB]);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W   = 19,
  parameter int          MEM_AW   = 11,
  parameter int          SECT_LSB = 9,
  parameter int          PROG_CYC = 8,
  parameter int          SECT_CYC = 600,
  parameter int          BANK_CYC = 2100,
  parameter logic [7:0]  DEV_CODE = 8'hC3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bank_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  logic              wr, rd_hit, start, id_mode, busy, is_prog, prog_d7;
  op_t               op;
  logic              ram_we;
  logic [MEM_AW-1:0] ram_wa, ram_ra, eng_ra;
  logic [7:0]        ram_wd, ram_q;
  logic              sel_ram_q, tog;
  logic [7:0]        stat_q;
  logic              id_hit;

  assign wr     = bank_sel && wr_en;
  assign rd_hit = bank_sel && rd_en && !wr_en;
  assign id_hit = id_mode && (addr[ADDR_W-1:1] == '0);
  assign ram_ra = busy ? eng_ra : addr[MEM_AW-1:0];

  fcd_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .wr       (wr),
    .cmd_addr (addr[14:0]),
    .wdata    (wdata),
    .busy     (busy),
    .start    (start),
    .op       (op),
    .id_mode  (id_mode)
  );

  fcd_engine #(
    .MEM_AW   (MEM_AW),
    .SECT_LSB (SECT_LSB),
    .PROG_CYC (PROG_CYC),
    .SECT_CYC (SECT_CYC),
    .BANK_CYC (BANK_CYC)
  ) u_eng (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op_in   (op),
    .addr_in (addr[MEM_AW-1:0]),
    .data_in (wdata),
    .ram_q   (ram_q),
    .busy    (busy),
    .is_prog (is_prog),
    .prog_d7 (prog_d7),
    .ram_we  (ram_we),
    .ram_wa  (ram_wa),
    .ram_wd  (ram_wd),
    .eng_ra  (eng_ra)
  );

  fcd_array #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk (clk),
    .we  (ram_we),
    .wa  (ram_wa),
    .wd  (ram_wd),
    .ra  (ram_ra),
    .q   (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_ram_q <= 1'b0;
      stat_q    <= '0;
      tog       <= 1'b0;
    end else if (rd_hit) begin
      if (busy) begin
        sel_ram_q <= 1'b0;
        stat_q    <= {(is_prog ? ~prog_d7 : 1'b0), tog, 6'b0};
        tog       <= ~tog;
      end else if (id_hit) begin
        sel_ram_q <= 1'b0;
        stat_q    <= addr[0] ? DEV_CODE : MAKER_CODE;
      end else begin
        sel_ram_q <= 1'b1;
      end
    end
  end

  assign rdata = sel_ram_q ? ram_q : stat_q;

  // R6
  stat_low_chk: assert property (@(posedge clk) disable iff (rst)
    rd_hit && busy |=> rdata[5:0] == 6'd0);

  // R6
  erase_dq7_chk: assert property (@(posedge clk) disable iff (rst)
    rd_hit && busy && !is_prog |=> !rdata[7]);

  // R7
  toggle_chk: assert property (@(posedge clk) disable iff (rst)
    rd_hit && busy && $past(rd_hit && busy) |=> rdata[6] != $past(rdata[6]));

  // R8
  busy_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr));
endmodule

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;
  localparam int PROG_CYC = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bank_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  int          total = 0, bad = 0;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.PROG_CYC(PROG_CYC)) dut (
    .clk(clk), .rst(rst), .bank_sel(bank_sel), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  // kind: 0 write, 1 read+check, 2 poll until done; {kind,req,addr,data}
  localparam int NV = 46;
  localparam logic [32:0] VEC [NV] = '{
    // R1
    {2'd0,4'd1,19'h05555,8'hAA}, {2'd0,4'd1,19'h02AAA,8'h55},
    {2'd0,4'd1,19'h05555,8'hA0}, {2'd0,4'd1,19'h00100,8'h3C},
    {2'd2,4'd1,19'h00100,8'h00}, {2'd1,4'd1,19'h00100,8'h3C},
    // R2
    {2'd0,4'd2,19'h05555,8'hAA}, {2'd0,4'd2,19'h02AAA,8'h55},
    {2'd0,4'd2,19'h05555,8'hA0}, {2'd0,4'd2,19'h00100,8'hF5},
    {2'd2,4'd2,19'h00100,8'h00}, {2'd1,4'd2,19'h00100,8'h34},
    // R3
    {2'd0,4'd3,19'h75555,8'hAA}, {2'd0,4'd3,19'h4AAAA,8'h55},
    {2'd0,4'd3,19'h35555,8'hA0}, {2'd0,4'd3,19'h00101,8'h81},
    {2'd2,4'd3,19'h00101,8'h00}, {2'd1,4'd3,19'h00101,8'h81},
    // R10
    {2'd0,4'd10,19'h05555,8'hAA}, {2'd0,4'd10,19'h02AAA,8'h55},
    {2'd0,4'd10,19'h05555,8'h90}, {2'd1,4'd10,19'h00000,8'hBF},
    {2'd1,4'd10,19'h00001,8'hC3}, {2'd1,4'd10,19'h00002,8'hFF},
    {2'd0,4'd10,19'h05555,8'hAA}, {2'd0,4'd10,19'h02AAA,8'h55},
    {2'd0,4'd10,19'h05555,8'hF0}, {2'd1,4'd10,19'h00000,8'hFF},
    {2'd0,4'd10,19'h05555,8'hAA}, {2'd0,4'd10,19'h02AAA,8'h55},
    {2'd0,4'd10,19'h05555,8'h90}, {2'd1,4'd10,19'h00001,8'hC3},
    {2'd0,4'd10,19'h00123,8'hF0}, {2'd1,4'd10,19'h00001,8'hFF},
    // R9
    {2'd0,4'd9,19'h05555,8'hAA}, {2'd0,4'd9,19'h02AAB,8'h55},
    {2'd0,4'd9,19'h05555,8'hA0}, {2'd0,4'd9,19'h00200,8'h00},
    {2'd1,4'd9,19'h00200,8'hFF},
    // R12
    {2'd0,4'd12,19'h05555,8'hAA}, {2'd0,4'd12,19'h02AAA,8'h55},
    {2'd0,4'd12,19'h05555,8'h80}, {2'd0,4'd12,19'h05555,8'hAA},
    {2'd0,4'd12,19'h02AAA,8'h55}, {2'd0,4'd12,19'h01234,8'h10},
    {2'd1,4'd12,19'h00100,8'h34}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [18:0] a, input logic [7:0] d);
    bank_sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; bank_sel = 1'b0;
  endtask

  task automatic bus_rd(input logic [18:0] a, output logic [7:0] q);
    bank_sel = 1'b1; rd_en = 1'b1; addr = a;
    @(negedge clk);
    q = rdata;
    rd_en = 1'b0; bank_sel = 1'b0;
  endtask

  task automatic poll(input logic [18:0] a);
    logic [7:0] p, q;
    int n;
    n = 0;
    bus_rd(a, p);
    bus_rd(a, q);
    while (q !== p && n < 5000) begin
      p = q;
      bus_rd(a, q);
      n++;
    end
    if (n >= 5000) chk("poll timeout", 8'h00, 8'h01);
  endtask

  task automatic unlock_erase();
    bus_wr(19'h05555, 8'hAA); bus_wr(19'h02AAA, 8'h55);
    bus_wr(19'h05555, 8'h80); bus_wr(19'h05555, 8'hAA);
    bus_wr(19'h02AAA, 8'h55);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] q, prev;
    @(negedge clk); @(negedge clk);
    // R11 reset value
    chk("R11 rdata in reset", rdata, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 rdata after reset", rdata, 8'h00);
    bus_rd(19'h00000, q);
    chk("R11 read latency, erased byte", q, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  kind;
      logic [3:0]  req;
      logic [18:0] va;
      logic [7:0]  vd;
      {kind, req, va, vd} = VEC[i];
      case (kind)
        2'd0: bus_wr(va, vd);
        2'd1: begin
          bus_rd(va, q);
          total++;
          if (q !== vd) begin
            bad++;
            $display("FAIL R%0d vector %0d actual=%02h expected=%02h", req, i, q, vd);
          end
        end
        default: poll(va);
      endcase
    end

    // R8 busy window, R6 program status, R7 toggling
    bus_wr(19'h05555, 8'hAA); bus_wr(19'h02AAA, 8'h55);
    bus_wr(19'h05555, 8'hA0); bus_wr(19'h00300, 8'h5A);
    bank_sel = 1'b1; rd_en = 1'b1; addr = 19'h00300;
    prev = 8'h00;
    for (int k = 1; k <= PROG_CYC + 1; k++) begin
      @(negedge clk);
      if (k <= PROG_CYC) begin
        chk("R6 program status bit7 and low bits", rdata & 8'hBF, 8'h80);
        if (k > 1) chk("R7 toggle flips", {7'd0, rdata[6]}, {7'd0, ~prev[6]});
      end else begin
        chk("R8 data after PROG_CYC cycles", rdata, 8'h5A);
      end
      prev = rdata;
    end
    rd_en = 1'b0; bank_sel = 1'b0;
    bus_rd(19'h00300, q);
    chk("R7 toggle stopped", q, 8'h5A);

    // R8 writes during busy are ignored
    bus_wr(19'h05555, 8'hAA); bus_wr(19'h02AAA, 8'h55);
    bus_wr(19'h05555, 8'hA0); bus_wr(19'h00301, 8'h00);
    bus_wr(19'h05555, 8'hAA); bus_wr(19'h02AAA, 8'h55);
    bus_wr(19'h05555, 8'hA0); bus_wr(19'h00302, 8'h00);
    poll(19'h00301);
    bus_rd(19'h00301, q);
    chk("R8 first program landed", q, 8'h00);
    bus_rd(19'h00302, q);
    chk("R8 program issued while busy ignored", q, 8'hFF);

    // R4 sector erase of sector 1 (0x200..0x3FF)
    unlock_erase();
    bus_wr(19'h00250, 8'h30);
    bus_rd(19'h00250, q);
    chk("R6 erase status bit7 and low bits", q & 8'hBF, 8'h00);
    poll(19'h00300);
    bus_rd(19'h00300, q);
    chk("R4 sector byte erased", q, 8'hFF);
    bus_rd(19'h00301, q);
    chk("R4 sector byte erased 2", q, 8'hFF);
    bus_rd(19'h00100, q);
    chk("R4 other sector untouched", q, 8'h34);

    // R11 reset clears identifier mode
    bus_wr(19'h05555, 8'hAA); bus_wr(19'h02AAA, 8'h55);
    bus_wr(19'h05555, 8'h90);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 rdata after second reset", rdata, 8'h00);
    bus_rd(19'h00000, q);
    chk("R11 reset leaves ID mode", q, 8'hFF);

    // R5 bank erase
    unlock_erase();
    bus_wr(19'h05555, 8'h10);
    poll(19'h00100);
    bus_rd(19'h00100, q);
    chk("R5 bank erased 0x100", q, 8'hFF);
    bus_rd(19'h00101, q);
    chk("R5 bank erased 0x101", q, 8'hFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule